// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Light Controller

This block sequences the signals at a junction where a busy highway meets a lightly used farm road. The highway has right of way by default. A vehicle sensor on the farm road, together with two expiry flags from a built-in interval timer, steers a four-phase machine through highway-green, highway-yellow, farm-green and farm-yellow. The machine holds the highway green until a farm vehicle has waited and the long interval has passed. It gives the farm road a green only until that road is empty or the long interval runs out. Each yellow lasts the short interval.

Each road's lamp colour follows the present phase. A single-cycle strobe is a Mealy output: it is high in a cycle exactly when the sensed conditions will move the machine to another phase at the next clock edge. The same strobe restarts the internal timer. Both interval lengths are parameters, and the timer's expiry flags are brought out so a system can observe the timing.

Top module: `crossing_ctrl`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the machine enters the highway-green phase with the timer count at zero. In the cycle after that edge, `lamp_hwy` is green, `lamp_farm` is red, and `timer_start`, `short_done` and `long_done` are all low.
- R2: In highway-green, the machine moves to highway-yellow at the next edge only when `car_waiting` and `long_done` are both high. In every other case it stays in highway-green.
- R3: In highway-yellow, the machine moves to farm-green at the next edge when `short_done` is high, whatever `car_waiting` is. Otherwise it stays in highway-yellow.
- R4: In farm-green, the machine moves to farm-yellow at the next edge when `car_waiting` is low or `long_done` is high. Otherwise it stays in farm-green.
- R5: In farm-yellow, the machine returns to highway-green at the next edge when `short_done` is high, whatever `car_waiting` is. Otherwise it stays in farm-yellow.
- R6: The lamps are coded as 2'b00 red, 2'b01 yellow and 2'b10 green, and 2'b11 is never driven. The phase sets the lamps as follows: highway-green gives highway green and farm red; highway-yellow gives highway yellow and farm red; farm-green gives highway red and farm green; farm-yellow gives highway red and farm yellow.
- R7: `timer_start` is high in a cycle if and only if the present phase and inputs cause a change of phase at the next edge. It is low on every hold.
- R8: The timer count is cleared at each edge where `timer_start` is high, and otherwise advances by one per edge until it reaches LONG_CYCLES. `short_done` is high while the count is at least SHORT_CYCLES, and `long_done` is high while the count is at least LONG_CYCLES. LONG_CYCLES is greater than SHORT_CYCLES, and SHORT_CYCLES is at least 1.
- R9: At least one road shows red in every cycle, and the two roads are never green together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| car_waiting | input | 1 | Farm-road vehicle sensor |
| lamp_hwy | output | 2 | Highway lamp colour code |
| lamp_farm | output | 2 | Farm-road lamp colour code |
| timer_start | output | 1 | Phase-change strobe, also restarts the timer |
| short_done | output | 1 | Short interval has elapsed since the last restart |
| long_done | output | 1 | Long interval has elapsed since the last restart |

## Verification
The phase register can be seen on the lamp pair. A wrong phase therefore appears on `lamp_hwy` or `lamp_farm` in the cycle right after the faulty edge. A wrong next-phase decision also appears earlier, in the same cycle, as a wrong `timer_start`. A timer count that is off shifts the rise of `short_done` or `long_done` by that many cycles. That shift then delays or advances the next strobe and lamp change. The bench steps a model of the phase and count in lock step with the design and compares every output every cycle, so any such divergence is caught within one cycle of its first effect at the ports.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'd0,
        PH_HWY_WARN  = 2'd1,
        PH_FARM_GO   = 2'd2,
        PH_FARM_WARN = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        LAMP_RED   = 2'b00,
        LAMP_AMBER = 2'b01,
        LAMP_GREEN = 2'b10
    } lamp_t;

    typedef struct packed {
        lamp_t hwy;
        lamp_t farm;
    } lamp_pair_t;

    typedef struct packed {
        logic car;
        logic short_done;
        logic long_done;
    } sense_t;

    // Phase that follows p when its exit condition is met (fixed ring order).
    function automatic phase_t successor(input phase_t p);
        case (p)
            PH_HWY_GO:    return PH_HWY_WARN;
            PH_HWY_WARN:  return PH_FARM_GO;
            PH_FARM_GO:   return PH_FARM_WARN;
            default:      return PH_HWY_GO;
        endcase
    endfunction

    // Exit condition of each phase.
    function automatic logic leave_phase(input phase_t p, input sense_t s);
        case (p)
            PH_HWY_GO:    return s.car & s.long_done;
            PH_HWY_WARN:  return s.short_done;
            PH_FARM_GO:   return ~s.car | s.long_done;
            default:      return s.short_done;
        endcase
    endfunction

    function automatic lamp_pair_t lamps_for(input phase_t p);
        lamp_pair_t l;
        case (p)
            PH_HWY_GO:   begin l.hwy = LAMP_GREEN; l.farm = LAMP_RED;   end
            PH_HWY_WARN: begin l.hwy = LAMP_AMBER; l.farm = LAMP_RED;   end
            PH_FARM_GO:  begin l.hwy = LAMP_RED;   l.farm = LAMP_GREEN; end
            default:     begin l.hwy = LAMP_RED;   l.farm = LAMP_AMBER; end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/tlc_step_logic.sv
module tlc_step_logic
    import tlc_pkg::*;
(
    input  phase_t phase_q,
    input  sense_t sense,
    output phase_t phase_d,
    output logic   change
);
    always_comb begin
        change  = leave_phase(phase_q, sense);
        phase_d = change ? successor(phase_q) : phase_q;
    end
endmodule

// File: rtl/tlc_phase_reg.sv
module tlc_phase_reg
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_d,
    output phase_t phase_q
);
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_HWY_GO;
        else     phase_q <= phase_d;
    end
endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  phase_t     phase_q,
    output lamp_pair_t lamps
);
    always_comb lamps = lamps_for(phase_q);
endmodule

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int SHORT_CYCLES = 4,
    parameter int LONG_CYCLES  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam int CNT_W = $clog2(LONG_CYCLES + 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYCLES);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYCLES);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || restart)          count_q <= '0;
        else if (count_q != LONG_LIM) count_q <= count_q + 1'b1;
    end

    always_comb begin
        short_done = (count_q >= SHORT_LIM);
        long_done  = (count_q >= LONG_LIM);
    end
endmodule

// File: rtl/crossing_ctrl.sv
module crossing_ctrl #(
    parameter int SHORT_CYCLES = 4,
    parameter int LONG_CYCLES  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       car_waiting,
    output logic [1:0] lamp_hwy,
    output logic [1:0] lamp_farm,
    output logic       timer_start,
    output logic       short_done,
    output logic       long_done
);
    import tlc_pkg::*;

    phase_t     phase_q;
    phase_t     phase_d;
    sense_t     sense;
    lamp_pair_t lamps;
    logic       change;
    logic       t_short;
    logic       t_long;

    always_comb begin
        sense.car        = car_waiting;
        sense.short_done = t_short;
        sense.long_done  = t_long;
    end

    tlc_step_logic u_step (
        .phase_q (phase_q),
        .sense   (sense),
        .phase_d (phase_d),
        .change  (change)
    );

    tlc_phase_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .phase_q (phase_q)
    );

    tlc_lamp_decode u_lamps (
        .phase_q (phase_q),
        .lamps   (lamps)
    );

    tlc_interval_timer #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart    (change),
        .short_done (t_short),
        .long_done  (t_long)
    );

    always_comb begin
        lamp_hwy    = lamps.hwy;
        lamp_farm   = lamps.farm;
        timer_start = change;
        short_done  = t_short;
        long_done   = t_long;
    end
endmodule

// File: rtl/crossing_ctrl_chk.sv
module crossing_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       car_waiting,
    input logic [1:0] lamp_hwy,
    input logic [1:0] lamp_farm,
    input logic       timer_start,
    input logic       short_done,
    input logic       long_done
);
    localparam logic [1:0] C_RED   = 2'b00;
    localparam logic [1:0] C_AMBER = 2'b01;
    localparam logic [1:0] C_GREEN = 2'b10;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (lamp_hwy == C_GREEN && lamp_farm == C_RED && !short_done && !long_done));

    // R2
    hwy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_hwy == C_GREEN && !(car_waiting && long_done)) |=> lamp_hwy == C_GREEN);

    // R3
    hwy_warn_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_hwy == C_AMBER && short_done) |=> lamp_farm == C_GREEN);

    // R4
    farm_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_farm == C_GREEN && (!car_waiting || long_done)) |=> lamp_farm == C_AMBER);

    // R6
    no_code3_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_hwy != 2'b11 && lamp_farm != 2'b11);

    // R7
    strobe_moves_chk: assert property (@(posedge clk) disable iff (rst)
        timer_start |=> (lamp_hwy != $past(lamp_hwy) || lamp_farm != $past(lamp_farm)));

    // R7
    quiet_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !timer_start |=> ($stable(lamp_hwy) && $stable(lamp_farm)));

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        timer_start |=> (!short_done && !long_done));

    // R8
    long_implies_short_chk: assert property (@(posedge clk) disable iff (rst)
        long_done |-> short_done);

    // R8
    short_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (short_done && !timer_start) |=> short_done);

    // R9
    one_red_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_hwy == C_RED || lamp_farm == C_RED);
endmodule

bind crossing_ctrl crossing_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .car_waiting (car_waiting),
    .lamp_hwy    (lamp_hwy),
    .lamp_farm   (lamp_farm),
    .timer_start (timer_start),
    .short_done  (short_done),
    .long_done   (long_done)
);

// File: tb/sim_crossing_ctrl.sv
`timescale 1ns/1ps
module sim_crossing_ctrl;
    localparam int S_CYC = 3;
    localparam int L_CYC = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       car_waiting = 1'b0;
    logic [1:0] lamp_hwy;
    logic [1:0] lamp_farm;
    logic       timer_start;
    logic       short_done;
    logic       long_done;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // model of phase (0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow) and count
    int m_phase = 0;
    int m_cnt   = 0;

    always #2.5 clk = ~clk;

    crossing_ctrl #(.SHORT_CYCLES(S_CYC), .LONG_CYCLES(L_CYC)) u0 (
        .clk(clk), .rst(rst), .car_waiting(car_waiting),
        .lamp_hwy(lamp_hwy), .lamp_farm(lamp_farm),
        .timer_start(timer_start), .short_done(short_done), .long_done(long_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    function automatic int exp_hwy(input int p);
        return (p == 0) ? 2 : (p == 1) ? 1 : 0;
    endfunction

    function automatic int exp_farm(input int p);
        return (p == 2) ? 2 : (p == 3) ? 1 : 0;
    endfunction

    // One normal cycle: drive at negedge, compare, then advance the model.
    task automatic step(input logic car);
        bit e_short, e_long, e_go;
        string tg;
        @(negedge clk);
        rst = 1'b0;
        car_waiting = car;
        #1;
        e_short = (m_cnt >= S_CYC);
        e_long  = (m_cnt >= L_CYC);
        case (m_phase)
            0: begin e_go = car && e_long;   tg = "R2/R7 strobe"; end
            1: begin e_go = e_short;         tg = "R3/R7 strobe"; end
            2: begin e_go = !car || e_long;  tg = "R4/R7 strobe"; end
            default: begin e_go = e_short;   tg = "R5/R7 strobe"; end
        endcase
        chk(lamp_hwy == 2'(exp_hwy(m_phase)), "R6 highway lamp", lamp_hwy, exp_hwy(m_phase));
        chk(lamp_farm == 2'(exp_farm(m_phase)), "R6 farm lamp", lamp_farm, exp_farm(m_phase));
        chk(timer_start == e_go, tg, timer_start, e_go);
        chk({short_done, long_done} == {e_short, e_long}, "R8 flags",
            {short_done, long_done}, {e_short, e_long});
        chk((lamp_hwy == 2'b00 || lamp_farm == 2'b00) && !(lamp_hwy == 2'b10 && lamp_farm == 2'b10),
            "R9 safety", {lamp_hwy, lamp_farm}, 0);
        if (e_go) begin
            m_phase = (m_phase + 1) % 4;
            m_cnt = 0;
        end else if (m_cnt < L_CYC) begin
            m_cnt++;
        end
    endtask

    task automatic do_reset(input logic car);
        @(negedge clk);
        rst = 1'b1;
        car_waiting = car;
        @(negedge clk);
        m_phase = 0;
        m_cnt = 0;
        #1;
        // R1: reset state visible while reset is still asserted, after one edge
        chk(lamp_hwy == 2'b10 && lamp_farm == 2'b00, "R1 lamps", {lamp_hwy, lamp_farm}, 4'b1000);
        chk(!short_done && !long_done, "R1 flags", {short_done, long_done}, 0);
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        step(1'b0);
        chk(timer_start == 1'b0, "R1 strobe low after reset", timer_start, 0);
    endtask

    task automatic t_hold_without_car();
        do_reset(1'b0);
        for (int i = 0; i < L_CYC + 6; i++) step(1'b0);
        chk(lamp_hwy == 2'b10, "R2 highway held without car", lamp_hwy, 2);
    endtask

    task automatic t_car_always();
        do_reset(1'b0);
        for (int i = 0; i < 3 * (L_CYC + S_CYC) + 8; i++) step(1'b1);
    endtask

    task automatic t_farm_empties();
        do_reset(1'b0);
        for (int i = 0; i < L_CYC + S_CYC + 3; i++) step(1'b1);
        for (int i = 0; i < 2 * S_CYC + 4; i++) step(i < 2);
        for (int i = 0; i < 2; i++) step(1'b0);
    endtask

    task automatic t_patterned();
        do_reset(1'b0);
        for (int i = 0; i < 150; i++) step(((i * 7 + i / 5) % 3) != 0);
        for (int i = 0; i < 150; i++) step(((i / 4) % 5) < 3);
    endtask

    task automatic t_reset_midway();
        do_reset(1'b0);
        for (int i = 0; i < L_CYC + S_CYC + 3; i++) step(1'b1);
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) step(1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        t_reset();
        t_hold_without_car();
        t_car_always();
        t_farm_empties();
        t_patterned();
        t_reset_midway();
        done = 1;
        summary();
    end
endmodule